// File: doc/BRIEF.md
# Stereo Digital Attenuator with Automute

This block sits in a stereo audio sample path and scales each channel by its own volume code. Every input sample arrives with a strobe, is multiplied by a gain chosen from an 8-bit code in half-decibel steps, and leaves two clock cycles later with its own strobe. A single control can also flip the polarity of both outputs. A software request, or a detector for long silent passages, puts the block into soft mute. In soft mute the output fades geometrically toward zero and does not cut off at once.

The gain is built from two parts. The coarse part is a right shift by one bit for every twelve half-decibel steps. The fine part is a twelve-entry fraction table that covers the half-decibel steps in between. A separate control lets the right channel take the left channel's code, so that one write can set a balanced volume. The silence detector counts samples for which both channels are exactly zero and raises a flag once the run is long enough. While the detector is enabled, a raised flag mutes the path. The first non-zero sample on either channel ends the mute.

Top module: `stereo_atten`

## Requirements
- R1: Code 8'hFF passes the input sample unchanged (0 dB), and code 8'h00 gives an output of exactly 0 on that channel.
- R2: For a code c from 1 to 254, let s = 255 - c, j = s mod 12 and k = s / 12. The channel result is floor(x * T[j] / 2^(16+k)), where T[j] = round(65536 * 10^(-j/40)). This gives 0.5 dB per code step.
- R3: When the link select is 1 at the time a sample is accepted, the right channel of that sample uses the left channel's code. When the select is 0, each channel uses its own code.
- R4: A sample accepted with in_valid high at clock edge n produces out_valid high for one cycle after edge n+2. Between results, out_valid is low and both outputs hold their last values.
- R5: With the phase control set, both outputs are the negated attenuated values. The one value that cannot be negated, -2^23, saturates to 2^23-1.
- R6: With zero detect enabled, zero_flag rises once 1024 consecutive accepted samples have had both channels equal to 0, and it stays high while further zero samples arrive. With zero detect disabled, zero_flag stays 0.
- R7: An accepted sample with a non-zero value on either channel clears the zero run and drops zero_flag. That sample appears at the output unmuted.
- R8: For each sample accepted while mute is requested (or while the zero flag is active and enabled), each output y becomes y - (y >>> 6), and becomes 0 if -64 <= y < 64. When mute is released, the next output is the attenuated current input sample.
- R9: During and right after reset, out_valid, zero_flag and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| atten_left | input | 8 | Left volume code (8'hFF = 0 dB, 8'h00 = mute) |
| atten_right | input | 8 | Right volume code |
| link_lr | input | 1 | Right channel uses the left code |
| mute_req | input | 1 | Soft mute request |
| phase_inv | input | 1 | Invert polarity of both outputs |
| zd_enable | input | 1 | Enable silence detection and automute |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Processed left sample, signed |
| out_right | output | 24 | Processed right sample, signed |
| zero_flag | output | 1 | Long zero run detected |

## Verification
The hardest case to reach is the exact edge of the silence detector. The flag must still be low after the 1023rd all-zero sample and high after the 1024th, and a run broken by a single non-zero right-channel sample must start counting again from nothing. The stimulus sends exactly counted runs of zero samples. It does this with the detector enabled, with it disabled, and with a run interrupted just short of the limit. The full soft-mute decay is also walked from positive full scale until the output is zero. Every step of that decay is checked, including the cut to zero near the end.

// File: rtl/att_pkg.sv
package att_pkg;

    localparam int FRAC_W    = 17;
    localparam int FRAC_Q    = 16;
    localparam int STEP_DIV  = 12;
    localparam int LUT_IDX_W = 4;

    typedef struct packed {
        logic valid;
        logic mute;
        logic invert;
    } stage_ctrl_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    function automatic logic [FRAC_W-1:0] frac_lut(input logic [LUT_IDX_W-1:0] idx);
        case (idx)
            4'd0:    frac_lut = 17'd65536;
            4'd1:    frac_lut = 17'd61870;
            4'd2:    frac_lut = 17'd58409;
            4'd3:    frac_lut = 17'd55142;
            4'd4:    frac_lut = 17'd52057;
            4'd5:    frac_lut = 17'd49145;
            4'd6:    frac_lut = 17'd46396;
            4'd7:    frac_lut = 17'd43801;
            4'd8:    frac_lut = 17'd41350;
            4'd9:    frac_lut = 17'd39037;
            4'd10:   frac_lut = 17'd36854;
            4'd11:   frac_lut = 17'd34792;
            default: frac_lut = 17'd0;
        endcase
    endfunction

endpackage

// File: rtl/att_gain.sv
module att_gain
    import att_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] sample,
    input  logic        [CW-1:0] code,
    output logic signed [DW-1:0] att_q
);
    localparam int PW      = DW + FRAC_W + 1;
    localparam int SHAMT_W = $clog2(PW);

    logic [CW-1:0]        steps;
    logic [CW-1:0]        coarse;
    logic [LUT_IDX_W-1:0] fine;
    logic [FRAC_W-1:0]    frac;
    logic [SHAMT_W-1:0]   shamt;
    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] scaled;

    always_comb begin
        steps  = ~code;
        coarse = steps / CW'(STEP_DIV);
        fine   = LUT_IDX_W'(steps % CW'(STEP_DIV));
        frac   = frac_lut(fine);
        shamt  = SHAMT_W'(FRAC_Q) + SHAMT_W'(coarse);
        prod   = $signed(sample) * $signed({1'b0, frac});
        scaled = (code == '0) ? '0 : DW'(prod >>> shamt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            att_q <= '0;
        end else if (en) begin
            att_q <= scaled;
        end
    end

    p_mute_code_r1: assert property (@(posedge clk) disable iff (rst)
        (en && code == '0) |=> (att_q == '0));

    p_unity_code_r1: assert property (@(posedge clk) disable iff (rst)
        (en && code == '1) |=> (att_q == $past(sample)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(att_q));

endmodule

// File: rtl/zero_run.sv
module zero_run #(
    parameter int DW      = 24,
    parameter int RUN_LEN = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] right,
    output logic          full_q,
    output logic          full_d
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             both_zero;

    always_comb begin
        both_zero = (left == '0) && (right == '0);
        cnt_d     = cnt_q;
        if (en) begin
            if (!both_zero) begin
                cnt_d = '0;
            end else if (cnt_q != CNT_W'(RUN_LEN)) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        full_d = (cnt_d == CNT_W'(RUN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            full_q <= full_d;
        end
    end

    p_clear_on_data_r7: assert property (@(posedge clk) disable iff (rst)
        (en && !both_zero) |=> !full_q);

    p_run_edge_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> ($past(cnt_q) == CNT_W'(RUN_LEN - 1)));

endmodule

// File: rtl/att_out.sv
module att_out #(
    parameter int DW       = 24,
    parameter int DECAY_SH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 mute,
    input  logic                 invert,
    input  logic signed [DW-1:0] att,
    output logic signed [DW-1:0] out_q
);
    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic signed [DW-1:0] tail;
    logic signed [DW-1:0] decayed;
    logic signed [DW-1:0] signed_val;
    logic signed [DW-1:0] nxt;

    always_comb begin
        tail    = out_q >>> DECAY_SH;
        decayed = ((tail == '0) || (tail == '1)) ? '0 : (out_q - tail);
        if (!invert) begin
            signed_val = att;
        end else if (att == MOST_NEG) begin
            signed_val = MOST_POS;
        end else begin
            signed_val = -att;
        end
        nxt = mute ? decayed : signed_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (en) begin
            out_q <= nxt;
        end
    end

    p_decay_rest_r8: assert property (@(posedge clk) disable iff (rst)
        (en && mute && out_q == '0) |=> (out_q == '0));

    p_decay_shrink_r8: assert property (@(posedge clk) disable iff (rst)
        (en && mute && out_q > 0) |=> (out_q >= 0 && out_q < $past(out_q)));

    p_phase_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !mute && invert && att > 0) |=> (out_q < 0));

    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q));

endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
    import att_pkg::*;
#(
    parameter int DW       = 24,
    parameter int CW       = 8,
    parameter int RUN_LEN  = 1024,
    parameter int DECAY_SH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    input  logic        [CW-1:0] atten_left,
    input  logic        [CW-1:0] atten_right,
    input  logic                 link_lr,
    input  logic                 mute_req,
    input  logic                 phase_inv,
    input  logic                 zd_enable,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right,
    output logic                 zero_flag
);
    localparam int NCH = 2;

    stage_ctrl_t          s1_q;
    logic                 out_valid_q;
    logic                 run_full_q;
    logic                 run_full_d;
    logic signed [DW-1:0] ch_in   [NCH];
    logic        [CW-1:0] ch_code [NCH];
    logic signed [DW-1:0] ch_att  [NCH];
    logic signed [DW-1:0] ch_out  [NCH];

    always_comb begin
        ch_in[CH_LEFT]    = in_left;
        ch_in[CH_RIGHT]   = in_right;
        ch_code[CH_LEFT]  = atten_left;
        ch_code[CH_RIGHT] = link_lr ? atten_left : atten_right;
    end

    zero_run #(
        .DW      (DW),
        .RUN_LEN (RUN_LEN)
    ) u_zero (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .left   (in_left),
        .right  (in_right),
        .full_q (run_full_q),
        .full_d (run_full_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q        <= '0;
            out_valid_q <= 1'b0;
        end else begin
            s1_q.valid  <= in_valid;
            out_valid_q <= s1_q.valid;
            if (in_valid) begin
                s1_q.mute   <= mute_req | (zd_enable & run_full_d);
                s1_q.invert <= phase_inv;
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        att_gain #(
            .DW (DW),
            .CW (CW)
        ) u_gain (
            .clk    (clk),
            .rst    (rst),
            .en     (in_valid),
            .sample (ch_in[ch]),
            .code   (ch_code[ch]),
            .att_q  (ch_att[ch])
        );

        att_out #(
            .DW       (DW),
            .DECAY_SH (DECAY_SH)
        ) u_out (
            .clk    (clk),
            .rst    (rst),
            .en     (s1_q.valid),
            .mute   (s1_q.mute),
            .invert (s1_q.invert),
            .att    (ch_att[ch]),
            .out_q  (ch_out[ch])
        );
    end

    assign out_valid = out_valid_q;
    assign out_left  = ch_out[CH_LEFT];
    assign out_right = ch_out[CH_RIGHT];
    assign zero_flag = zd_enable & run_full_q;

    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    p_automute_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zd_enable && run_full_q && in_left == '0 && in_right == '0)
        |=> s1_q.mute);

    p_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> !out_valid);

endmodule

// File: tb/stereo_atten_test.sv
module stereo_atten_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic        [7:0]  atten_left = 8'hFF;
    logic        [7:0]  atten_right = 8'hFF;
    logic               link_lr = 1'b0;
    logic               mute_req = 1'b0;
    logic               phase_inv = 1'b0;
    logic               zd_enable = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;
    logic               zero_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    longint exp_l = 0;
    longint exp_r = 0;
    int     zrun = 0;

    always #5 clk = ~clk;

    stereo_atten uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .atten_left(atten_left), .atten_right(atten_right),
        .link_lr(link_lr), .mute_req(mute_req), .phase_inv(phase_inv),
        .zd_enable(zd_enable), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right), .zero_flag(zero_flag)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint gain(input longint x, input int c);
        int s, j, k;
        longint t;
        if (c == 0) return 0;
        s = 255 - c;
        j = s % 12;
        k = s / 12;
        t = longint'($floor($pow(10.0, -j / 40.0) * 65536.0 + 0.5));
        return (x * t) >>> (16 + k);
    endfunction

    function automatic longint decay(input longint y);
        if (y >= -64 && y < 64) return 0;
        return y - (y >>> 6);
    endfunction

    function automatic longint negsat(input longint v);
        if (v == -8388608) return 8388607;
        return -v;
    endfunction

    task automatic send(input longint l, input longint r, input string tag);
        longint prev_l, prev_r, gl, gr;
        bit mute;
        int rcode;
        prev_l = exp_l;
        prev_r = exp_r;
        if (l == 0 && r == 0) begin
            if (zrun < 1024) zrun++;
        end else begin
            zrun = 0;
        end
        mute  = mute_req || (zd_enable && zrun >= 1024);
        rcode = link_lr ? int'(atten_left) : int'(atten_right);
        if (mute) begin
            exp_l = decay(exp_l);
            exp_r = decay(exp_r);
        end else begin
            gl = gain(l, int'(atten_left));
            gr = gain(r, rcode);
            exp_l = phase_inv ? negsat(gl) : gl;
            exp_r = phase_inv ? negsat(gr) : gr;
        end
        @(negedge clk);
        in_left  = 24'(l);
        in_right = 24'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4", "valid low mid-pipe", longint'(out_valid), 0);
        chk("R4", "left hold", longint'(out_left), prev_l);
        chk("R4", "right hold", longint'(out_right), prev_r);
        @(negedge clk);
        chk("R4", "valid after two edges", longint'(out_valid), 1);
        chk(tag, "left", longint'(out_left), exp_l);
        chk(tag, "right", longint'(out_right), exp_r);
        chk(tag, "zero flag", longint'(zero_flag), (zd_enable && zrun >= 1024) ? 1 : 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint pats [4] = '{8388607, -8388608, 1234567, -99};
        repeat (3) @(negedge clk);
        chk("R9", "valid in reset", longint'(out_valid), 0);
        chk("R9", "flag in reset", longint'(zero_flag), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "valid after reset", longint'(out_valid), 0);
        chk("R9", "left after reset", longint'(out_left), 0);
        chk("R9", "right after reset", longint'(out_right), 0);
        chk("R9", "flag after reset", longint'(zero_flag), 0);

        // R1 / R2: every code on the left, mirrored code on the right
        for (int c = 0; c < 256; c++) begin
            atten_left  = 8'(c);
            atten_right = 8'(255 - c);
            for (int p = 0; p < 4; p++) begin
                if (c == 0 || c == 255) send(pats[p], pats[3 - p], "R1");
                else send(pats[p], pats[3 - p], "R2");
            end
        end

        // R3: right follows left code when linked
        atten_left = 8'd230;
        atten_right = 8'd10;
        link_lr = 1'b1;
        send(3000000, 3000000, "R3");
        send(-4000000, 777777, "R3");
        link_lr = 1'b0;
        send(3000000, 3000000, "R3");

        // R5: polarity flip with saturation
        phase_inv = 1'b1;
        atten_left = 8'hFF;
        atten_right = 8'd200;
        send(-8388608, 8388607, "R5");
        send(8388607, -8388608, "R5");
        atten_right = 8'hFF;
        send(123, -8388608, "R5");
        phase_inv = 1'b0;

        // R8: soft-mute decay from full scale, then release
        send(8388607, -8388608, "R8");
        mute_req = 1'b1;
        for (int n = 0; n < 800; n++) send(1000, -1000, "R8");
        mute_req = 1'b0;
        send(4321, -5555, "R8");
        mute_req = 1'b1;
        for (int n = 0; n < 40; n++) send(0, 0, "R8");
        mute_req = 1'b0;

        // R6 / R7: zero run detection
        zd_enable = 1'b1;
        send(5, 5, "R7");
        for (int n = 0; n < 1023; n++) send(0, 0, "R6");
        send(0, 0, "R6");
        for (int n = 0; n < 5; n++) send(0, 0, "R6");
        send(0, 777, "R7");
        for (int n = 0; n < 1020; n++) send(0, 0, "R6");
        send(0, -3, "R7");
        for (int n = 0; n < 1023; n++) send(0, 0, "R6");
        send(0, 0, "R6");
        send(-42, 0, "R7");
        zd_enable = 1'b0;
        for (int n = 0; n < 1100; n++) send(0, 0, "R6");

        finish_run();
    end

endmodule